// File: doc/BRIEF.md
# SPI Serial Flash Command Engine

This block is the serial-side controller of a small page-organised NOR-style flash model. It listens to an SPI bus in clock mode 0 or 3, assembles an 8-bit opcode and an optional 24-bit address, and then serves the command. Supported commands are plain and fast reads, status reads, write-latch set and clear, page program, page write, page erase, sector erase, bulk erase, deep power-down and wake-up. The storage is an on-chip register array built from 256-byte pages.

The serial lines are synchronised to the system clock, and edges of the serial clock are detected from the synchronised copy. A write-type command collects its data in a page buffer. The command takes effect only when chip select is released on a whole-byte boundary and the write-enable latch was set beforehand. Each internal cycle is then modelled by a down-counter whose length is a parameter. While that counter runs, the engine answers only status reads. After a power-down command it responds only to the wake-up opcode. The data-out line comes with a separate drive-enable signal, which stands in for a tri-state pin.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset the status byte reads 00h, every memory byte reads FFh, and the output enable is low.
- R2: Opcode 03h, followed by a 24-bit address, returns bytes from consecutive addresses. Data bits shift out MSB first and change on SCK falling edges, for as long as chip select stays low. Address bits above the array index (including bits 23:20) are ignored, and the address wraps at the end of the array.
- R3: Opcode 0Bh behaves like 03h, except that one dummy byte follows the address before data starts.
- R4: Opcode 05h returns the status byte repeatedly, with bit 0 = write in progress, bit 1 = write-enable latch and the other bits 0. Opcode 06h sets the latch and opcode 04h clears it.
- R5: Page program (02h), page write (0Ah), page erase (DBh), sector erase (D8h, 512-byte sectors) and bulk erase (C7h) have no effect unless the write-enable latch is set.
- R6: A write-type command is discarded, with the latch kept, when chip select rises after a bit count that is not a multiple of eight.
- R7: Page program stores old AND new in each byte it receives. Bytes it does not receive are left unchanged.
- R8: Page write sets every byte of the addressed page that it does not receive to FFh. Each byte it receives is stored exactly.
- R9: During programming, the byte offset wraps within the 256-byte page. A later byte sent to the same offset replaces the earlier one.
- R10: Page, sector and bulk erase set every byte of their region to FFh and leave all other bytes unchanged.
- R11: After a commit, status bit 0 reads 1 until the busy count expires, and memory reads drive nothing during that time. The write-enable latch clears when the cycle ends.
- R12: After opcode B9h, every opcode except ABh is ignored, and ABh restores normal operation. A B9h sent while busy is rejected.
- R13: The output enable is low whenever chip select is high and during opcode and address bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Drive enable for miso_o |

## Verification
A latch or busy counter in the wrong state shows up at the ports within one transaction. The status byte read straight after a commit gives the wrong bit, or a read during busy drives data when it should stay silent. A buffer or offset error appears only when the affected page is read back, so every write is followed by a read of the bytes around it, including the wrapped offsets. A misaligned or unauthorised commit shows up as changed memory on that read-back.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_FAST = 8'h0B;
  localparam logic [7:0] OPC_PW   = 8'h0A;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_PE   = 8'hDB;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;
  localparam logic [7:0] OPC_DP   = 8'hB9;
  localparam logic [7:0] OPC_RDP  = 8'hAB;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_DUMMY, ST_RD, ST_STAT, ST_PGM, ST_ERS, ST_IGN
  } st_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_PWR, OP_PERASE, OP_SERASE, OP_BERASE
  } op_e;
endpackage

// File: rtl/sfe_spi_phy.sv
module sfe_spi_phy (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       cs_act_o,
  output logic       cs_rise_o,
  output logic       bit_aligned_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  input  logic       tx_en_i,
  input  logic [7:0] tx_byte_i,
  output logic       tx_take_o,
  output logic       miso_o,
  output logic       miso_oe_o
);
  logic sck_s1, sck_s2, sck_d;
  logic cs_s1, cs_s2, cs_d;
  logic mosi_s1, mosi_s2;
  logic [2:0] bit_cnt, out_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic sck_rise, sck_fall;

  assign cs_act_o      = !cs_s2;
  assign cs_rise_o     = cs_s2 && !cs_d;
  assign sck_rise      = sck_s2 && !sck_d && cs_act_o;
  assign sck_fall      = !sck_s2 && sck_d && cs_act_o;
  assign bit_aligned_o = (bit_cnt == 3'd0);
  assign tx_take_o     = sck_fall && tx_en_i && (out_cnt == 3'd0);
  assign miso_o        = tx_sr[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {sck_s1, sck_s2, sck_d} <= '0;
      {cs_s1, cs_s2, cs_d}    <= '1;
      {mosi_s1, mosi_s2}      <= '0;
    end else begin
      sck_s1 <= sck_i;  sck_s2 <= sck_s1;  sck_d <= sck_s2;
      cs_s1  <= cs_ni;  cs_s2  <= cs_s1;   cs_d  <= cs_s2;
      mosi_s1 <= mosi_i; mosi_s2 <= mosi_s1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!cs_act_o) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s2};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {rx_sr, mosi_s2};
        end
      end
    end
  end

  // output byte loads on the falling edge that starts it, then shifts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_cnt   <= '0;
      tx_sr     <= '0;
      miso_oe_o <= 1'b0;
    end else if (!cs_act_o) begin
      out_cnt   <= '0;
      miso_oe_o <= 1'b0;
    end else if (sck_fall && tx_en_i) begin
      out_cnt <= out_cnt + 3'd1;
      if (out_cnt == 3'd0) begin
        tx_sr     <= tx_byte_i;
        miso_oe_o <= 1'b1;
      end else begin
        tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  AST_OE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_o |=> !miso_oe_o); // R13
endmodule

// File: rtl/sfe_store.sv
module sfe_store
  import sfe_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 512,
  localparam int AW   = $clog2(MEM_BYTES),
  localparam int PB_W = $clog2(PAGE_BYTES),
  localparam int SB_W = $clog2(SECTOR_BYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            go_i,
  input  op_e             op_i,
  input  logic [AW-PB_W-1:0] page_i,
  input  logic [AW-SB_W-1:0] sector_i,
  input  logic            buf_clr_i,
  input  logic            buf_we_i,
  input  logic [PB_W-1:0] buf_idx_i,
  input  logic [7:0]      buf_din_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [7:0]      rd_data_o
);
  logic [7:0] mem  [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];

  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (buf_clr_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else if (buf_we_i) begin
      pbuf[buf_idx_i] <= buf_din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (go_i) begin
      case (op_i)
        OP_PROG:
          for (int i = 0; i < PAGE_BYTES; i++)
            mem[{page_i, PB_W'(i)}] <= mem[{page_i, PB_W'(i)}] & pbuf[i];
        OP_PWR:
          for (int i = 0; i < PAGE_BYTES; i++) mem[{page_i, PB_W'(i)}] <= pbuf[i];
        OP_PERASE:
          for (int i = 0; i < PAGE_BYTES; i++) mem[{page_i, PB_W'(i)}] <= 8'hFF;
        OP_SERASE:
          for (int i = 0; i < SECTOR_BYTES; i++) mem[{sector_i, SB_W'(i)}] <= 8'hFF;
        OP_BERASE:
          for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        default: ;
      endcase
    end
  end

  AST_NO_BUF_RACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !buf_we_i); // R9
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
  import sfe_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 512,
  parameter int PROG_CYCLES  = 3000,
  parameter int ERASE_CYCLES = 6000,
  parameter int BULK_CYCLES  = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int PB_W  = $clog2(PAGE_BYTES);
  localparam int SB_W  = $clog2(SECTOR_BYTES);
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ?
                         ((PROG_CYCLES > BULK_CYCLES) ? PROG_CYCLES : BULK_CYCLES) :
                         ((ERASE_CYCLES > BULK_CYCLES) ? ERASE_CYCLES : BULK_CYCLES);
  localparam int BUSY_W = $clog2(MAXC + 1);

  logic cs_act, cs_rise, bit_aligned, rx_valid, tx_take;
  logic [7:0] rx_byte, tx_byte, rd_data;
  st_e  state;
  op_e  op_q;
  logic fast_q, wel_q, pd_q, data_seen, commit_q;
  logic [1:0] addr_cnt;
  logic [AW-1:0] addr_q;
  logic [PB_W-1:0] pg_off;
  logic [BUSY_W-1:0] busy_cnt, cyc_sel;
  logic busy, buf_clr, buf_we, tx_en;

  assign busy    = (busy_cnt != '0);
  assign tx_en   = (state == ST_RD) || (state == ST_STAT);
  assign tx_byte = (state == ST_STAT) ? {6'b0, wel_q, busy} : rd_data;
  assign buf_we  = rx_valid && cs_act && (state == ST_PGM);
  assign buf_clr = rx_valid && cs_act && (state == ST_CMD) && !pd_q && !busy && wel_q &&
                   ((rx_byte == OPC_PP) || (rx_byte == OPC_PW));

  always_comb begin
    case (op_q)
      OP_PROG, OP_PWR:       cyc_sel = BUSY_W'(PROG_CYCLES);
      OP_PERASE, OP_SERASE:  cyc_sel = BUSY_W'(ERASE_CYCLES);
      default:               cyc_sel = BUSY_W'(BULK_CYCLES);
    endcase
  end

  sfe_spi_phy i_phy (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .cs_act_o(cs_act), .cs_rise_o(cs_rise), .bit_aligned_o(bit_aligned),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .tx_en_i(tx_en), .tx_byte_i(tx_byte), .tx_take_o(tx_take),
    .miso_o, .miso_oe_o
  );

  sfe_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) i_store (
    .clk_i, .rst_ni, .go_i(commit_q), .op_i(op_q),
    .page_i(addr_q[AW-1:PB_W]), .sector_i(addr_q[AW-1:SB_W]),
    .buf_clr_i(buf_clr), .buf_we_i(buf_we), .buf_idx_i(pg_off), .buf_din_i(rx_byte),
    .rd_addr_i(addr_q), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_CMD;  op_q <= OP_NONE;  fast_q <= 1'b0;
      wel_q <= 1'b0;    pd_q <= 1'b0;     data_seen <= 1'b0;
      commit_q <= 1'b0; addr_cnt <= '0;   addr_q <= '0;
      pg_off <= '0;     busy_cnt <= '0;
    end else begin
      commit_q <= 1'b0;
      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == BUSY_W'(1)) wel_q <= 1'b0;
      end
      if (!cs_act) begin
        // commit only on a whole-byte release of a complete write command
        if (cs_rise && bit_aligned && wel_q && !busy &&
            ((state == ST_PGM && data_seen) || state == ST_ERS)) begin
          commit_q <= 1'b1;
          busy_cnt <= cyc_sel;
        end
        state <= ST_CMD;  data_seen <= 1'b0;  addr_cnt <= '0;
      end else if (rx_valid) begin
        case (state)
          ST_CMD: begin
            state <= ST_IGN;
            if (pd_q) begin
              if (rx_byte == OPC_RDP) pd_q <= 1'b0;
            end else if (busy) begin
              if (rx_byte == OPC_RDSR) state <= ST_STAT;
            end else begin
              case (rx_byte)
                OPC_WREN: wel_q <= 1'b1;
                OPC_WRDI: wel_q <= 1'b0;
                OPC_RDSR: state <= ST_STAT;
                OPC_READ: begin fast_q <= 1'b0; op_q <= OP_NONE; state <= ST_ADDR; end
                OPC_FAST: begin fast_q <= 1'b1; op_q <= OP_NONE; state <= ST_ADDR; end
                OPC_PP:   begin op_q <= OP_PROG;   if (wel_q) state <= ST_ADDR; end
                OPC_PW:   begin op_q <= OP_PWR;    if (wel_q) state <= ST_ADDR; end
                OPC_PE:   begin op_q <= OP_PERASE; if (wel_q) state <= ST_ADDR; end
                OPC_SE:   begin op_q <= OP_SERASE; if (wel_q) state <= ST_ADDR; end
                OPC_BE:   begin op_q <= OP_BERASE; if (wel_q) state <= ST_ERS;  end
                OPC_DP:   pd_q <= 1'b1;
                default: ;
              endcase
            end
          end
          ST_ADDR: begin
            addr_q   <= AW'({addr_q, rx_byte});
            addr_cnt <= addr_cnt + 2'd1;
            if (addr_cnt == 2'd2) begin
              case (op_q)
                OP_NONE: state <= fast_q ? ST_DUMMY : ST_RD;
                OP_PROG, OP_PWR: begin
                  state  <= ST_PGM;
                  pg_off <= PB_W'({addr_q, rx_byte});
                end
                default: state <= ST_ERS;
              endcase
            end
          end
          ST_DUMMY: state <= ST_RD;
          ST_PGM: begin
            data_seen <= 1'b1;
            pg_off    <= pg_off + 1'b1;
          end
          ST_ERS: state <= ST_IGN;
          default: ;
        endcase
      end else if (tx_take && state == ST_RD) begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  AST_COMMIT_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> wel_q); // R5
  AST_COMMIT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> $past(bit_aligned)); // R6
  AST_BUSY_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (state != ST_RD && state != ST_PGM && state != ST_ERS)); // R11
  AST_WEL_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel_q); // R11
  AST_PD_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> !busy); // R12
  AST_PD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> !tx_en); // R12
endmodule

// File: tb/test_spi_flash_engine.sv
module test_spi_flash_engine;
  localparam int MEM = 1024;
  localparam int PROGC = 1500, ERSC = 1500, BULKC = 2500;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  int n_chk = 0, n_fail = 0, cs_hi = 0;
  bit done = 1'b0;

  byte unsigned mem_m [MEM];
  bit wel_m = 0, busy_m = 0, pd_m = 0;

  always #4 clk = ~clk;

  spi_flash_engine #(.MEM_BYTES(MEM), .PAGE_BYTES(256), .SECTOR_BYTES(512),
    .PROG_CYCLES(PROGC), .ERASE_CYCLES(ERSC), .BULK_CYCLES(BULKC)) i_spi_flash_engine (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every clock: output enable must be low while chip select is high (R13)
  always @(negedge clk) begin
    if (cs_n) cs_hi++; else cs_hi = 0;
    if (rst_n && cs_hi > 4) chk(!miso_oe, "R13 oe while deselected", miso_oe, 0);
  end

  task automatic spi_start();
    @(negedge clk); cs_n = 1'b0; sck = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic spi_stop();
    repeat (HP) @(negedge clk); cs_n = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic spi_byte(input byte unsigned tx, output byte unsigned rx, output int oe_n);
    oe_n = 0;
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HP) @(negedge clk);
      rx[b] = miso;
      oe_n += int'(miso_oe);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send_hdr(input byte unsigned opc, input int a, input bit with_addr, input string req);
    byte unsigned rx; int oe;
    spi_byte(opc, rx, oe);
    chk(oe == 0, req, oe, 0);
    if (with_addr)
      for (int k = 2; k >= 0; k--) begin
        spi_byte(byte'(a >> (8 * k)), rx, oe);
        chk(oe == 0, "R13 oe during address", oe, 0);
      end
  endtask

  task automatic simple(input byte unsigned opc);
    spi_start(); send_hdr(opc, 0, 0, "R13 oe during opcode"); spi_stop();
    if (pd_m) begin
      if (opc == 8'hAB) pd_m = 0;
    end else if (!busy_m) begin
      if (opc == 8'h06) wel_m = 1;
      if (opc == 8'h04) wel_m = 0;
      if (opc == 8'hB9) pd_m = 1;
    end
  endtask

  task automatic stat(input string req);
    byte unsigned rx, exp; int oe;
    exp = {6'b0, wel_m, busy_m};
    spi_start(); send_hdr(8'h05, 0, 0, "R13 oe during opcode");
    for (int k = 0; k < 2; k++) begin
      spi_byte(8'h00, rx, oe);
      if (pd_m) chk(oe == 0, {req, " silent"}, oe, 0);
      else begin
        chk(rx == exp, req, rx, exp);
        chk(oe == 8, {req, " oe"}, oe, 8);
      end
    end
    spi_stop();
  endtask

  task automatic rd(input int a, input int n, input bit fast, input string req);
    byte unsigned rx; int oe; int ai;
    spi_start(); send_hdr(fast ? 8'h0B : 8'h03, a, 1, "R13 oe during opcode");
    if (fast) begin spi_byte(8'h00, rx, oe); chk(oe == 0, "R3 dummy silent", oe, 0); end
    ai = a % MEM;
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, rx, oe);
      if (busy_m || pd_m) chk(oe == 0, {req, " silent"}, oe, 0);
      else begin
        chk(rx == mem_m[(ai + k) % MEM], req, rx, mem_m[(ai + k) % MEM]);
        chk(oe == 8, {req, " oe"}, oe, 8);
      end
    end
    spi_stop();
  endtask

  task automatic wait_idle(input string req);
    repeat (BULKC + 100) @(negedge clk);
    if (busy_m) begin busy_m = 0; wel_m = 0; end
    stat(req);
  endtask

  task automatic prog(input byte unsigned opc, input int a, input byte unsigned d[$], input int extra);
    byte unsigned rx; int oe; byte unsigned pb [256]; int base;
    spi_start(); send_hdr(opc, a, 1, "R13 oe during opcode");
    foreach (d[k]) spi_byte(d[k], rx, oe);
    for (int k = 0; k < extra; k++) begin
      mosi = 1'b0; repeat (HP) @(negedge clk); sck = 1'b1; repeat (HP) @(negedge clk); sck = 1'b0;
    end
    spi_stop();
    if (wel_m && !busy_m && !pd_m && extra == 0 && d.size() > 0) begin
      base = (a % MEM) & ~255;
      foreach (pb[i]) pb[i] = 8'hFF;
      foreach (d[k]) pb[(a + k) & 255] = d[k];
      for (int i = 0; i < 256; i++)
        mem_m[base + i] = (opc == 8'h02) ? (mem_m[base + i] & pb[i]) : pb[i];
      busy_m = 1;
    end
  endtask

  task automatic erase(input byte unsigned opc, input int a);
    int lo, sz;
    spi_start(); send_hdr(opc, a, opc != 8'hC7, "R13 oe during opcode"); spi_stop();
    if (wel_m && !busy_m && !pd_m) begin
      sz = (opc == 8'hDB) ? 256 : (opc == 8'hD8) ? 512 : MEM;
      lo = (a % MEM) & ~(sz - 1);
      for (int i = 0; i < sz; i++) mem_m[lo + i] = 8'hFF;
      busy_m = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    byte unsigned d[$];
    foreach (mem_m[i]) mem_m[i] = 8'hFF;
    repeat (5) @(negedge clk);
    chk(miso_oe == 0, "R1 oe after reset", miso_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    stat("R1 status after reset");
    rd(0, 2, 0, "R1 erased array");

    simple(8'h06); stat("R4 latch set");
    simple(8'h04); stat("R4 latch cleared");

    d = '{8'h12, 8'h34};
    prog(8'h02, 'h10, d, 0); stat("R5 no commit without latch");
    rd('h10, 2, 0, "R5 memory unchanged");

    simple(8'h06);
    d = '{8'hA5, 8'h3C, 8'h0F};
    prog(8'h02, 'hFE, d, 0);
    stat("R11 busy after commit");
    rd('hFE, 2, 0, "R11 read during busy");
    simple(8'hB9);
    wait_idle("R11 latch clear at end");
    rd('hFE, 2, 0, "R9 page wrap high");
    rd(0, 1, 0, "R9 page wrap low");
    rd(0, 1, 0, "R12 power-down during busy rejected");

    simple(8'h06);
    d = '{8'hF0};
    prog(8'h02, 'hFE, d, 0); wait_idle("R7 idle");
    rd('hFE, 1, 0, "R7 program ANDs");

    simple(8'h06);
    d = '{8'h00};
    prog(8'h02, 'h40, d, 3); stat("R6 misaligned keeps latch");
    rd('h40, 1, 0, "R6 misaligned discarded");

    d = '{8'h00};
    prog(8'h02, 'h105, d, 0); wait_idle("R7 idle 2");
    simple(8'h06);
    d = '{8'h11, 8'h22, 8'h33};
    prog(8'h0A, 'h110, d, 0); wait_idle("R8 idle");
    rd('h104, 2, 0, "R8 page write refills");
    rd('h10F, 5, 0, "R8 page write data");

    simple(8'h06);
    d = {};
    for (int k = 0; k < 258; k++) d.push_back(byte'(k + 7));
    prog(8'h02, 'h200, d, 0); wait_idle("R9 idle");
    rd('h200, 3, 0, "R9 overwrite earliest");
    rd('h2FE, 2, 0, "R9 tail bytes");

    rd('hF00101, 2, 1, "R3 fast read high bits ignored");
    rd('h3FE, 4, 0, "R2 stream wraps array");

    simple(8'h06); erase(8'hDB, 'h0FF); wait_idle("R10 idle");
    rd('hFE, 2, 0, "R10 page erased");
    rd('h100, 1, 0, "R10 neighbour page kept");
    simple(8'h06); erase(8'hD8, 'h3AB); wait_idle("R10 idle 2");
    rd('h1FF, 2, 0, "R10 sector boundary");
    d = '{8'h5A};
    simple(8'h06); prog(8'h02, 'h120, d, 0); wait_idle("R10 idle 3");
    simple(8'h06); erase(8'hC7, 0); wait_idle("R10 idle 4");
    rd('h10F, 3, 0, "R10 bulk erase");
    rd('h120, 1, 0, "R10 bulk erase 2");

    simple(8'hB9);
    rd(0, 1, 0, "R12 read ignored asleep");
    simple(8'h06); stat("R12 status ignored asleep");
    simple(8'hAB); stat("R12 awake, latch still clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule